// File: doc/BRIEF.md
# Playback Block Counter with DMA Request and Completion Interrupt

This unit sits between the playback path of an audio codec and the system DMA controller. While playback is enabled it holds a DMA request so that the controller delivers sample bytes. Each accepted byte is one cycle with both the request and the acknowledge high. The unit counts those bytes. Software programs a 16-bit block length in frames as two bytes. A frame-size shift turns that length into a byte target. When the count reaches the target, the unit reports completion and starts the next block on its own.

Completion is reported in three ways. Two one-cycle set pulses go to the status logic: one for the global interrupt bit and one for the playback-interrupt flag. An interrupt line stays high until the status logic pulses a clear. Block tracking only runs while interrupt enable is set. Without it, bytes keep flowing and no completion is ever reported. The request is not started when programmed I/O playback is selected.

Top module: `pb_dma_tracker`

## Requirements
- R1: After reset `dma_req`, `int_set`, `pi_set` and `irq_line` are all 0, and playback is stopped.
- R2: From the stopped state, `pb_enable`=1 with `pio_mode`=0 raises `dma_req` after the next clock edge. While playing, `pb_enable`=0 drops `dma_req` after the next clock edge, and a byte offered in that cycle is not counted.
- R3: From the stopped state, `pb_enable`=1 together with `pio_mode`=1 does not start playback, and `dma_req` stays 0.
- R4: The byte target is `{count_hi,count_lo}` shifted left by `frame_shift` (0 to 3). With `irq_enable`=1, completion follows exactly that many accepted bytes.
- R5: On completion `int_set` and `pi_set` are both high for exactly one cycle, in the cycle after the edge that accepted the last byte. The counter then restarts, so the next block takes a full target of bytes.
- R6: With `irq_enable`=0, no completion is reported, however many bytes are accepted.
- R7: `dma_req` is 0 in the cycle where the completion pulses are high, and an acknowledge in that cycle is not counted.
- R8: `irq_line` rises with the completion pulses and stays high until a cycle with `irq_clear`=1. A completion in the same cycle as a clear leaves the line high.
- R9: Each start from the stopped state begins counting at 0. Bytes accepted before a stop do not count toward the next block.
- R10: The target is latched at start and at each block boundary. Rewriting `count_hi`/`count_lo` mid-block changes the length of the following block only.
- R11: While `irq_enable`=1 and the latched target is 0, `dma_req` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pb_enable | input | 1 | Playback enable |
| pio_mode | input | 1 | Programmed I/O playback selected; blocks a start |
| irq_enable | input | 1 | Enables block tracking and the interrupt |
| count_hi | input | 8 | Upper byte of the block length in frames |
| count_lo | input | 8 | Lower byte of the block length in frames |
| frame_shift | input | 2 | log2 of bytes per frame |
| dma_ack | input | 1 | One byte delivered when high together with `dma_req` |
| irq_clear | input | 1 | Clears the interrupt line (status-port write) |
| dma_req | output | 1 | DMA request |
| int_set | output | 1 | One-cycle pulse that sets the global status INT bit |
| pi_set | output | 1 | One-cycle pulse that sets the playback-interrupt flag |
| irq_line | output | 1 | Sticky interrupt output |

## Verification
Two events can meet in one cycle: a block completing, which sets the interrupt line, and the status logic clearing that line. The bench provokes this in two ways. A directed case holds `irq_clear` high across a whole block. In the random phase, sparse clear pulses land on completion cycles. Each cycle the line is judged against a bench model that gives the set priority, so a lost interrupt shows up. A second overlap is an acknowledge in the completion cycle: the model does not count it, and the block length that follows must still be full.

// File: rtl/pb_pkg.sv
package pb_pkg;
    localparam int PB_BYTE_W  = 8;
    localparam int PB_SHIFT_W = 2;
    localparam int PB_CNT_W   = 2 * PB_BYTE_W + (1 << PB_SHIFT_W) - 1;

    typedef struct packed {
        logic                run;
        logic                hold;
        logic                tc;
        logic [PB_CNT_W-1:0] cnt;
        logic [PB_CNT_W-1:0] tgt;
    } pb_state_t;
endpackage

// File: rtl/pb_target_calc.sv
module pb_target_calc #(
    parameter int BYTE_W  = 8,
    parameter int SHIFT_W = 2,
    parameter int CNT_W   = 2 * BYTE_W + (1 << SHIFT_W) - 1
) (
    input  logic [BYTE_W-1:0]  hi,
    input  logic [BYTE_W-1:0]  lo,
    input  logic [SHIFT_W-1:0] shift,
    output logic [CNT_W-1:0]   target
);
    localparam int BASE_W = 2 * BYTE_W;

    logic [CNT_W-1:0] base_ext;

    always_comb begin
        base_ext = '0;
        base_ext[BASE_W-1:0] = {hi, lo};
        target = base_ext << shift;
    end
endmodule

// File: rtl/pb_sticky_irq.sv
module pb_sticky_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    logic q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (clr) q_d = 1'b0;
        if (set) q_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= 1'b0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/pb_dma_tracker.sv
module pb_dma_tracker
    import pb_pkg::*;
#(
    parameter int BYTE_W  = PB_BYTE_W,
    parameter int SHIFT_W = PB_SHIFT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pb_enable,
    input  logic               pio_mode,
    input  logic               irq_enable,
    input  logic [BYTE_W-1:0]  count_hi,
    input  logic [BYTE_W-1:0]  count_lo,
    input  logic [SHIFT_W-1:0] frame_shift,
    input  logic               dma_ack,
    input  logic               irq_clear,
    output logic               dma_req,
    output logic               int_set,
    output logic               pi_set,
    output logic               irq_line
);
    localparam int CNT_W = PB_CNT_W;

    pb_state_t        st_d, st_q;
    logic [CNT_W-1:0] tgt_new;
    logic             accepted;
    logic             hit;

    pb_target_calc #(
        .BYTE_W (BYTE_W),
        .SHIFT_W(SHIFT_W),
        .CNT_W  (CNT_W)
    ) u_tgt (
        .hi    (count_hi),
        .lo    (count_lo),
        .shift (frame_shift),
        .target(tgt_new)
    );

    // Request: running, not in the post-completion gap, target usable
    always_comb begin
        dma_req = st_q.run && !st_q.hold && !(irq_enable && (st_q.tgt == '0));
    end

    always_comb begin
        accepted = dma_ack && dma_req;
        hit      = irq_enable && ((st_q.cnt + CNT_W'(1)) == st_q.tgt);
        st_d      = st_q;
        st_d.tc   = 1'b0;
        st_d.hold = 1'b0;
        if (!st_q.run) begin
            if (pb_enable && !pio_mode) begin
                st_d.run = 1'b1;
                st_d.cnt = '0;
                st_d.tgt = tgt_new;
            end
        end else if (!pb_enable) begin
            st_d.run = 1'b0;
        end else if (accepted) begin
            if (hit) begin
                st_d.cnt  = '0;
                st_d.tgt  = tgt_new;
                st_d.hold = 1'b1;
                st_d.tc   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pb_sticky_irq u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (st_d.tc),
        .clr  (irq_clear),
        .q    (irq_line)
    );

    assign int_set = st_q.tc;
    assign pi_set  = st_q.tc;
endmodule

// File: rtl/pb_dma_tracker_chk.sv
module pb_dma_tracker_chk (
    input logic clk,
    input logic rst_n,
    input logic pb_enable,
    input logic irq_enable,
    input logic irq_clear,
    input logic dma_req,
    input logic int_set,
    input logic pi_set,
    input logic irq_line
);
    AST_PULSE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        int_set |-> irq_line); // R8
    AST_GAP_AFTER_TC: assert property (@(posedge clk) disable iff (!rst_n)
        pi_set |-> !dma_req); // R7
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        int_set |=> !int_set); // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_line && !irq_clear) |=> irq_line); // R8
    AST_NO_TC_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        int_set |-> $past(irq_enable)); // R6
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(pb_enable)); // R2
endmodule

bind pb_dma_tracker pb_dma_tracker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pb_enable (pb_enable),
    .irq_enable(irq_enable),
    .irq_clear (irq_clear),
    .dma_req   (dma_req),
    .int_set   (int_set),
    .pi_set    (pi_set),
    .irq_line  (irq_line)
);

// File: tb/sim_pb_dma_tracker.sv
module sim_pb_dma_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pb_enable = 1'b0, pio_mode = 1'b0, irq_enable = 1'b0;
    logic [7:0] count_hi = '0, count_lo = '0;
    logic [1:0] frame_shift = '0;
    logic       dma_ack = 1'b0, irq_clear = 1'b0;
    logic       dma_req, int_set, pi_set, irq_line;

    int n_tests = 0, n_fail = 0;
    string tag = "R1";

    // bench model
    logic        m_run, m_hold, m_tc, m_irq;
    logic [18:0] m_cnt, m_tgt;
    int          acc_seen, tc_seen;

    always #4 clk = ~clk;

    pb_dma_tracker u0 (
        .clk(clk), .rst_n(rst_n), .pb_enable(pb_enable), .pio_mode(pio_mode),
        .irq_enable(irq_enable), .count_hi(count_hi), .count_lo(count_lo),
        .frame_shift(frame_shift), .dma_ack(dma_ack), .irq_clear(irq_clear),
        .dma_req(dma_req), .int_set(int_set), .pi_set(pi_set), .irq_line(irq_line)
    );

    function automatic logic [18:0] calc_tgt(logic [7:0] h, logic [7:0] l, logic [1:0] s);
        logic [18:0] b;
        b = {3'b000, h, l};
        return b << s;
    endfunction

    function automatic logic exp_req();
        return m_run && !m_hold && !(irq_enable && m_tgt == 19'd0);
    endfunction

    task automatic check(input logic ok, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_edge(input logic acc);
        logic set;
        set = 1'b0;
        m_tc = 1'b0;
        if (!m_run) begin
            if (pb_enable && !pio_mode) begin
                m_run = 1'b1; m_cnt = '0; m_tgt = calc_tgt(count_hi, count_lo, frame_shift);
            end
            m_hold = 1'b0;
        end else if (!pb_enable) begin
            m_run = 1'b0; m_hold = 1'b0;
        end else begin
            m_hold = 1'b0;
            if (acc) begin
                if (irq_enable && (m_cnt + 19'd1) == m_tgt) begin
                    m_cnt = '0; m_tgt = calc_tgt(count_hi, count_lo, frame_shift);
                    m_hold = 1'b1; m_tc = 1'b1; set = 1'b1;
                end else begin
                    m_cnt = m_cnt + 19'd1;
                end
            end
        end
        if (set) m_irq = 1'b1;
        else if (irq_clear) m_irq = 1'b0;
    endtask

    task automatic step();
        logic acc;
        acc = dma_ack && exp_req();
        @(posedge clk);
        model_edge(acc);
        if (acc) acc_seen++;
        #1;
        if (int_set) tc_seen++;
        check(dma_req == exp_req(), "dma_req", dma_req, exp_req());
        check(int_set == m_tc, "int_set", int_set, m_tc);
        check(pi_set == m_tc, "pi_set", pi_set, m_tc);
        check(irq_line == m_irq, "irq_line", irq_line, m_irq);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pb_enable = 0; pio_mode = 0; irq_enable = 0; dma_ack = 0; irq_clear = 0;
        repeat (3) @(posedge clk);
        m_run = 0; m_hold = 0; m_tc = 0; m_irq = 0; m_cnt = '0; m_tgt = '0;
        #1;
        tag = "R1";
        check({dma_req, int_set, pi_set, irq_line} == 4'b0, "reset outputs",
              {dma_req, int_set, pi_set, irq_line}, 0);
        rst_n = 1'b1;
    endtask

    // run with continuous ack until a completion pulse, return bytes accepted
    task automatic run_block(output int bytes);
        acc_seen = 0; tc_seen = 0;
        dma_ack = 1'b1;
        for (int i = 0; i < 3000 && tc_seen == 0; i++) step();
        bytes = acc_seen;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog R1: got hang expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int b;
        void'($urandom(32'h5eed1234));
        do_reset();

        // R2: start and stop
        tag = "R2";
        count_hi = 0; count_lo = 5; frame_shift = 0; irq_enable = 1;
        pb_enable = 1; step();
        check(dma_req == 1'b1, "req after enable", dma_req, 1);
        pb_enable = 0; dma_ack = 1; step();
        check(dma_req == 1'b0, "req after disable", dma_req, 0);
        dma_ack = 0; step();

        // R3: pio blocks start
        tag = "R3";
        pio_mode = 1; pb_enable = 1;
        for (int i = 0; i < 6; i++) begin
            step();
            check(dma_req == 1'b0, "pio start blocked", dma_req, 0);
        end
        pb_enable = 0; pio_mode = 0; step();

        // R4 / R5 / R7: 3 frames x 2 bytes = 6 bytes, twice
        tag = "R4";
        count_hi = 0; count_lo = 3; frame_shift = 1; pb_enable = 1; step();
        run_block(b);
        check(b == 6, "block length", b, 6);
        tag = "R7";
        check(dma_req == 1'b0, "gap after completion", dma_req, 0);
        tag = "R5";
        run_block(b);
        check(b == 6, "second block length", b, 6);
        tag = "R4";
        count_hi = 8'h01; count_lo = 8'h00; frame_shift = 0;
        pb_enable = 0; dma_ack = 0; step(); pb_enable = 1; step();
        run_block(b);
        check(b == 256, "upper byte target", b, 256);

        // R10: mid-block rewrite
        tag = "R10";
        count_hi = 0; count_lo = 4; frame_shift = 0;
        pb_enable = 0; dma_ack = 0; step(); pb_enable = 1; step();
        dma_ack = 1; step(); step();
        count_lo = 9;
        run_block(b);
        check(b == 2, "rest of old block", b, 2);
        run_block(b);
        check(b == 9, "new block length", b, 9);

        // R9: stop mid-block then restart
        tag = "R9";
        dma_ack = 1; step(); step(); step();
        pb_enable = 0; step(); pb_enable = 1; dma_ack = 0; step();
        run_block(b);
        check(b == 9, "restart from zero", b, 9);

        // R6: no completion without irq enable
        tag = "R6";
        irq_enable = 0; count_lo = 2;
        acc_seen = 0; tc_seen = 0; dma_ack = 1;
        for (int i = 0; i < 40; i++) step();
        check(tc_seen == 0, "pulses unarmed", tc_seen, 0);

        // R8: clear held across completion
        tag = "R8";
        pb_enable = 0; dma_ack = 0; step();
        irq_enable = 1; count_lo = 3; pb_enable = 1; step();
        irq_clear = 1;
        run_block(b);
        check(irq_line == 1'b1, "set beats clear", irq_line, 1);
        dma_ack = 0; step();
        check(irq_line == 1'b0, "clear after", irq_line, 0);
        irq_clear = 0;

        // R11: zero target stalls
        tag = "R11";
        pb_enable = 0; step();
        count_hi = 0; count_lo = 0; pb_enable = 1; step();
        for (int i = 0; i < 5; i++) begin
            dma_ack = 1; step();
            check(dma_req == 1'b0, "zero target request", dma_req, 0);
        end

        // random phase
        tag = "R5";
        for (int i = 0; i < 4000; i++) begin
            dma_ack     = ($urandom % 4) != 0;
            irq_clear   = ($urandom % 16) == 0;
            if (($urandom % 200) == 0) pb_enable = ~pb_enable;
            if (($urandom % 150) == 0) irq_enable = ~irq_enable;
            if (($urandom % 100) == 0) pio_mode = ~pio_mode;
            if (($urandom % 30) == 0) begin
                count_lo = 8'($urandom % 8);
                frame_shift = 2'($urandom % 3);
            end
            step();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule